// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one burst request into a stream of column addresses, one per data beat, for a DDR SDRAM-style memory. A configuration load captures the burst length (2, 4 or 8 beats), the beat ordering (sequential or interleaved) and the CAS latency (2 or 2.5 cycles) from a 13-bit address word. The same load can also request a DLL reset. An upper-bit pattern that is not defined makes the block reject the load.

A burst begins when a starting column is accepted on the start channel. The low bits of that column choose the first beat inside an aligned block whose size is the burst length. The bits above them choose the block, and they are held for the whole burst. Each beat is offered on a valid/ready output channel. When `col_ready` is low, the current address and last flag stay on the outputs and the beat does not advance. `start_ready` is high only while no burst is running. A start offered while a burst runs is not taken, and `start_overrun` is raised in that cycle.

Top module: `ddr_colseq`

## Requirements
- R1: After reset, no burst is active. `col_valid` is 0, `start_ready` is 1, the configuration reads length 4, sequential order and CAS latency 2, and `dll_reset_req` and `mrs_error` are 0.
- R2: A load with `mrs_addr[12:7]` all zero applies all three fields, and the new values show on the config outputs one cycle later. The fields are: `mrs_addr[2:0]` is the length code (001 = 2, 010 = 4, 011 = 8); `mrs_addr[3]` is the order (0 = sequential, 1 = interleaved); `mrs_addr[6:4]` is the CAS latency (010 = 2, 110 = 2.5, which shows as `cfg_cas_half` = 1).
- R3: In an accepted load, a length code outside 001/010/011 keeps the previous length, and a CAS code outside 010/110 keeps the previous latency. The order bit is still applied.
- R4: A load whose upper bits are exactly A8 = 1 (`mrs_addr[12:7]` = 000010) applies the settings as in R2 and pulses `dll_reset_req` for one cycle.
- R5: A load with any other nonzero upper-bit pattern pulses `mrs_error` for one cycle and leaves the configuration unchanged.
- R6: In sequential order, beat k has low bits (s + k) mod L, where s is the starting column and L is the burst length.
- R7: In interleaved order, beat k has low bits s XOR k, taken within the log2(L) low bits.
- R8: Every beat keeps the start's column bits above log2(L), so a burst never leaves its aligned block.
- R9: The first beat is valid in the cycle after the start handshake. `col_last` is high only on beat L-1, and `col_valid` falls in the cycle after that beat is accepted.
- R10: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_last` hold their values, and the beat advances only on a handshake.
- R11: A start offered during a burst sees `start_ready` = 0 and `start_overrun` = 1 in that cycle. It is ignored, and the running burst's addresses are unchanged.
- R12: A burst uses the configuration that was in force at its start handshake. A load during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_load | input | 1 | Configuration load strobe |
| mrs_addr | input | 13 | Configuration address word |
| cfg_burst_len | output | 4 | Stored burst length in beats (2, 4, 8) |
| cfg_interleaved | output | 1 | Stored order, 1 = interleaved |
| cfg_cas_half | output | 1 | Stored CAS latency, 1 = 2.5, 0 = 2 |
| dll_reset_req | output | 1 | One-cycle DLL reset request |
| mrs_error | output | 1 | One-cycle rejected-load flag |
| start_valid | input | 1 | Burst start offered |
| start_col | input | COL_W | Starting column address |
| start_ready | output | 1 | Start can be accepted (no burst active) |
| start_overrun | output | 1 | Start offered while a burst is active |
| col_valid | output | 1 | Column beat valid |
| col_ready | input | 1 | Consumer accepts the beat |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
The hardest cases to reach from the ports are the ones where things overlap during a running burst: a start arriving mid-burst, a configuration load arriving mid-burst, and a stalled consumer. The bench starts an eight-beat interleaved burst and withholds `col_ready` on some beats. Partway through, it offers a second start and also loads a different configuration. It then checks that every remaining beat still follows the original start and settings. Around that case, it sweeps all lengths, both orders and sixteen starting columns, with several high-bit patterns and back-pressure on every other burst.

// File: rtl/ddr_colseq_pkg.sv
package ddr_colseq_pkg;
  localparam int OFS_W = 3;               // offset bits for the largest burst (8)
  localparam int LG_W  = 2;               // log2(length) code width

  localparam logic [2:0] BLC_2 = 3'b001;
  localparam logic [2:0] BLC_4 = 3'b010;
  localparam logic [2:0] BLC_8 = 3'b011;
  localparam logic [2:0] CLC_2  = 3'b010;
  localparam logic [2:0] CLC_25 = 3'b110;

  typedef struct packed {
    logic [LG_W-1:0] len_lg;
    logic            interleaved;
    logic            cas_half;
  } colseq_cfg_t;

  function automatic logic [OFS_W-1:0] ofs_mask(input logic [LG_W-1:0] lg);
    return OFS_W'((1 << lg) - 1);
  endfunction

  function automatic logic [OFS_W-1:0] beat_ofs(input logic [OFS_W-1:0] s,
                                                input logic [OFS_W-1:0] k,
                                                input logic [LG_W-1:0]  lg,
                                                input logic             il);
    logic [OFS_W-1:0] m;
    m = ofs_mask(lg);
    return il ? ((s ^ k) & m) : ((s + k) & m);
  endfunction
endpackage

// File: rtl/ddr_colseq_modereg.sv
module ddr_colseq_modereg
  import ddr_colseq_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output colseq_cfg_t       cfg,
  output logic              dll_req,
  output logic              err
);
  localparam int UP_W = MODE_W - 7;
  localparam logic [UP_W-1:0] UP_DLL = UP_W'(2);   // only A8 set

  logic [UP_W-1:0] upper;
  logic            up_ok, up_dll;
  colseq_cfg_t     nxt;

  assign upper  = word[MODE_W-1:7];
  assign up_dll = (upper == UP_DLL);
  assign up_ok  = (upper == '0) || up_dll;

  always_comb begin
    nxt = cfg;
    nxt.interleaved = word[3];
    case (word[2:0])
      BLC_2:   nxt.len_lg = 2'd1;
      BLC_4:   nxt.len_lg = 2'd2;
      BLC_8:   nxt.len_lg = 2'd3;
      default: nxt.len_lg = cfg.len_lg;
    endcase
    case (word[6:4])
      CLC_2:   nxt.cas_half = 1'b0;
      CLC_25:  nxt.cas_half = 1'b1;
      default: nxt.cas_half = cfg.cas_half;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '{len_lg: 2'd2, interleaved: 1'b0, cas_half: 1'b0};
      dll_req <= 1'b0;
      err     <= 1'b0;
    end else begin
      dll_req <= load && up_dll;
      err     <= load && !up_ok;
      if (load && up_ok) cfg <= nxt;
    end
  end
endmodule

// File: rtl/ddr_colseq_addrmap.sv
module ddr_colseq_addrmap
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  input  logic [LG_W-1:0]  len_lg,
  input  logic             interleaved,
  output logic [COL_W-1:0] addr,
  output logic             is_last
);
  localparam int HI_W = COL_W - OFS_W;

  logic [OFS_W-1:0] m, low;
  logic [COL_W-1:0] m_full;

  assign m       = ofs_mask(len_lg);
  assign m_full  = {{HI_W{1'b0}}, m};
  assign low     = beat_ofs(base[OFS_W-1:0], beat, len_lg, interleaved);
  assign addr    = (base & ~m_full) | {{HI_W{1'b0}}, low};
  assign is_last = (beat == m);
endmodule

// File: rtl/ddr_colseq_beatgen.sv
module ddr_colseq_beatgen
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  colseq_cfg_t      cfg,
  input  logic             start_valid,
  input  logic [COL_W-1:0] start_col,
  output logic             start_ready,
  output logic             start_overrun,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic             busy, fire, last_w;
  logic [OFS_W-1:0] k;
  logic [COL_W-1:0] base;
  logic [LG_W-1:0]  lg_q;
  logic             il_q;

  assign start_ready   = !busy;
  assign fire          = start_valid && !busy;
  assign start_overrun = start_valid && busy;
  assign col_valid     = busy;
  assign col_last      = busy && last_w;

  ddr_colseq_addrmap #(.COL_W(COL_W)) u_map (
    .base(base), .beat(k), .len_lg(lg_q), .interleaved(il_q),
    .addr(col_addr), .is_last(last_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      k    <= '0;
      base <= '0;
      lg_q <= 2'd1;
      il_q <= 1'b0;
    end else if (fire) begin
      busy <= 1'b1;
      k    <= '0;
      base <= start_col;
      lg_q <= cfg.len_lg;
      il_q <= cfg.interleaved;
    end else if (busy && col_ready) begin
      if (last_w) busy <= 1'b0;
      else        k    <= k + 1'b1;
    end
  end
endmodule

// File: rtl/ddr_colseq.sv
module ddr_colseq
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_load,
  input  logic [MODE_W-1:0] mrs_addr,
  output logic [3:0]        cfg_burst_len,
  output logic              cfg_interleaved,
  output logic              cfg_cas_half,
  output logic              dll_reset_req,
  output logic              mrs_error,
  input  logic              start_valid,
  input  logic [COL_W-1:0]  start_col,
  output logic              start_ready,
  output logic              start_overrun,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last
);
  colseq_cfg_t cfg;

  ddr_colseq_modereg #(.MODE_W(MODE_W)) u_mr (
    .clk(clk), .rst_n(rst_n), .load(mrs_load), .word(mrs_addr),
    .cfg(cfg), .dll_req(dll_reset_req), .err(mrs_error)
  );

  ddr_colseq_beatgen #(.COL_W(COL_W)) u_bg (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .start_valid(start_valid), .start_col(start_col),
    .start_ready(start_ready), .start_overrun(start_overrun),
    .col_valid(col_valid), .col_ready(col_ready),
    .col_addr(col_addr), .col_last(col_last)
  );

  assign cfg_burst_len   = 4'(1 << cfg.len_lg);
  assign cfg_interleaved = cfg.interleaved;
  assign cfg_cas_half    = cfg.cas_half;
endmodule

// File: rtl/ddr_colseq_chk.sv
module ddr_colseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cfg_burst_len,
  input logic             cfg_interleaved,
  input logic             cfg_cas_half,
  input logic             dll_reset_req,
  input logic             mrs_error,
  input logic             start_valid,
  input logic             start_ready,
  input logic             start_overrun,
  input logic             col_valid,
  input logic             col_ready,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last
);
  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  a_r9_first_beat_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> col_valid);

  a_r9_valid_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last) |=> !col_valid);

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  a_r8_block_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid && !(col_ready && col_last)))
      |-> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));

  a_r11_overrun_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_overrun |-> (col_valid && start_valid));

  a_r5_error_keeps_config: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_error |-> ($stable(cfg_burst_len) && $stable(cfg_interleaved) && $stable(cfg_cas_half)));

  a_r4_dll_not_with_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dll_reset_req, mrs_error}));
endmodule

bind ddr_colseq ddr_colseq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_ddr_colseq.sv
`timescale 1ns/1ps
module sim_ddr_colseq;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mrs_load = 1'b0;
  logic [12:0] mrs_addr = '0;
  logic [3:0] cfg_burst_len;
  logic cfg_interleaved, cfg_cas_half, dll_reset_req, mrs_error;
  logic start_valid = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic start_ready, start_overrun, col_valid, col_last;
  logic col_ready = 1'b1;
  logic [COL_W-1:0] col_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ddr_colseq #(.COL_W(COL_W)) u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int s, input int len, input bit il, input int k);
    int low;
    low = il ? ((s ^ k) & (len - 1)) : ((s + k) % len);
    return (s & ~(len - 1)) | low;
  endfunction

  function automatic logic [12:0] mword(input logic [5:0] up, input logic [2:0] cl,
                                        input logic bt, input logic [2:0] bl);
    return {up, cl, bt, bl};
  endfunction

  task automatic load_mode(input logic [12:0] w);
    @(negedge clk); mrs_load = 1'b1; mrs_addr = w;
    @(negedge clk); mrs_load = 1'b0;
  endtask

  // Runs one burst; stall withholds ready on one beat in three.
  task automatic burst(input int s, input int len, input bit il, input bit stall);
    int k = 0;
    int n = 0;
    @(negedge clk);
    chk("R9 start_ready idle", int'(start_ready), 1);
    start_valid = 1'b1; start_col = COL_W'(s);
    @(negedge clk);
    start_valid = 1'b0;
    while (k < len) begin
      col_ready = stall ? ((n % 3) != 1) : 1'b1;
      #1;
      chk("R9 col_valid", int'(col_valid), 1);
      chk(il ? "R7 R8 interleaved addr" : "R6 R8 sequential addr",
          int'(col_addr), exp_addr(s, len, il, k));
      chk("R9 col_last", int'(col_last), int'(k == len - 1));
      if (col_ready) k++;
      n++;
      @(negedge clk);
    end
    col_ready = 1'b1;
    chk("R9 valid drops after last", int'(col_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 col_valid", int'(col_valid), 0);
    chk("R1 start_ready", int'(start_ready), 1);
    chk("R1 len", int'(cfg_burst_len), 4);
    chk("R1 order", int'(cfg_interleaved), 0);
    chk("R1 cas", int'(cfg_cas_half), 0);
    chk("R1 flags", int'({dll_reset_req, mrs_error}), 0);

    // R2 normal load
    load_mode(mword(6'b0, 3'b110, 1'b1, 3'b011));
    chk("R2 len", int'(cfg_burst_len), 8);
    chk("R2 order", int'(cfg_interleaved), 1);
    chk("R2 cas 2.5", int'(cfg_cas_half), 1);
    chk("R2 no flags", int'({dll_reset_req, mrs_error}), 0);

    // R3 illegal length and CAS codes hold, order applies
    load_mode(mword(6'b0, 3'b001, 1'b0, 3'b111));
    chk("R3 len held", int'(cfg_burst_len), 8);
    chk("R3 order applied", int'(cfg_interleaved), 0);
    chk("R3 cas held", int'(cfg_cas_half), 1);
    chk("R3 no error", int'(mrs_error), 0);

    // R4 DLL reset request applies settings
    load_mode(mword(6'b000010, 3'b010, 1'b1, 3'b001));
    chk("R4 dll pulse", int'(dll_reset_req), 1);
    chk("R4 len", int'(cfg_burst_len), 2);
    chk("R4 cas 2", int'(cfg_cas_half), 0);
    chk("R4 order", int'(cfg_interleaved), 1);
    @(negedge clk);
    chk("R4 dll one cycle", int'(dll_reset_req), 0);

    // R5 reserved upper patterns rejected
    for (int p = 0; p < 3; p++) begin
      logic [5:0] up;
      up = (p == 0) ? 6'b000001 : (p == 1) ? 6'b000100 : 6'b100010;
      load_mode(mword(up, 3'b110, 1'b0, 3'b011));
      chk("R5 error pulse", int'(mrs_error), 1);
      chk("R5 dll quiet", int'(dll_reset_req), 0);
      chk("R5 len kept", int'(cfg_burst_len), 2);
      chk("R5 order kept", int'(cfg_interleaved), 1);
      chk("R5 cas kept", int'(cfg_cas_half), 0);
    end
    @(negedge clk);
    chk("R5 error one cycle", int'(mrs_error), 0);

    // R6 R7 R8 R9 R10 sweep
    for (int lg = 1; lg <= 3; lg++) begin
      for (int il = 0; il < 2; il++) begin
        load_mode(mword(6'b0, 3'b010, il[0], 3'(lg)));
        for (int s = 0; s < 16; s++)
          burst((s * 53 + lg * 129 + il * 300) % 1024, 1 << lg, il[0], s[0]);
      end
    end

    // R11 R12 start and load during an active burst
    load_mode(mword(6'b0, 3'b010, 1'b1, 3'b011));
    @(negedge clk);
    start_valid = 1'b1; start_col = 10'd725;
    @(negedge clk);
    start_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      col_ready = (k != 2);
      if (k == 3) begin
        start_valid = 1'b1; start_col = 10'd18;
        mrs_load = 1'b1; mrs_addr = mword(6'b0, 3'b010, 1'b0, 3'b001);
        #1;
        chk("R11 start_ready low", int'(start_ready), 0);
        chk("R11 overrun flag", int'(start_overrun), 1);
      end else begin
        start_valid = 1'b0; mrs_load = 1'b0;
        #1;
        chk("R11 no overrun", int'(start_overrun), 0);
      end
      chk("R11 R12 addr kept", int'(col_addr), exp_addr(725, 8, 1'b1, k));
      chk("R12 last", int'(col_last), int'(k == 7));
      if (!col_ready) begin
        @(negedge clk);
        col_ready = 1'b1; start_valid = 1'b0; mrs_load = 1'b0;
        #1;
        chk("R10 held addr", int'(col_addr), exp_addr(725, 8, 1'b1, k));
      end
      @(negedge clk);
    end
    start_valid = 1'b0; mrs_load = 1'b0; col_ready = 1'b1;
    chk("R11 ignored start", int'(col_valid), 0);
    chk("R12 new len later", int'(cfg_burst_len), 2);
    burst(18, 2, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule